// File: doc/BRIEF.md
# PWM Output Action Qualifier with Continuous Force

This block turns time-base events into two PWM output levels, A and B. A separate counter (outside this block) reports, on each time-base tick, which events happened in that tick: the counter reached zero, the counter reached the period, the counter matched compare A while counting up, and the counter matched compare B while counting up. Each output has its own control word. That word gives every event a 2-bit action: leave the output alone, drive it low, drive it high, or toggle it.

Software can also hold either output at a fixed level through a continuous force register. A written force value first goes into a shadow copy. It moves into the active copy at a programmable point: counter zero, period, either of the two, or the next tick. An active force beats every event action.

All configuration is written through a simple strobe-addressed write port. The event inputs and the tick enable come from the time-base counter.

Top module: `pwm_action_qual`

## Requirements
- R1: Every action is a 2-bit code. 00 leaves the output unchanged, 01 drives it low, 10 drives it high, and 11 inverts it. The output register changes only on a clock edge where `tick` is high.
- R2: The control word for output A is written at address 0, and for output B at address 1. In each word the zero-event action is at bits 1:0, the period-event action at bits 3:2, the compare-A-up action at bits 5:4, and the compare-B-up action at bits 9:8. The other bits are ignored.
- R3: Event inputs that arrive without `tick` have no effect. The result of a tick is visible on the outputs right after the clock edge that samples it.
- R4: Only events that are present and whose action is non-zero take part. Among those, compare B wins over compare A, compare A wins over period, and period wins over zero. An event whose action is 00 does not mask a lower-priority event.
- R5: The force register is at address 2, with bits 1:0 for output A and bits 3:2 for output B. An active code of 01 holds the output low and 10 holds it high. Codes 00 and 11 leave the output to the event actions. While a force is active, event actions do not change the output.
- R6: The force reload mode is at address 3, bits 1:0. In mode 00 a written force value becomes active on a tick that carries the zero event.
- R7: In reload mode 01 a written force value becomes active on a tick that carries the period event. A zero event does not load it.
- R8: In reload mode 10 a written force value becomes active on a tick that carries either the zero event or the period event.
- R9: In reload mode 11 a written force value acts on the very next tick, with or without events. The forced level appears right after that edge.
- R10: Reset (synchronous, active low) sets both outputs low. It also clears all action, force and reload fields to 0, so ticks after reset leave the outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the configuration registers |
| wr_addr | input | 2 | Register select: 0 ctl A, 1 ctl B, 2 force, 3 reload mode |
| wr_data | input | DW | Write data |
| tick | input | 1 | Time-base clock enable; events count only when high |
| evt_zero | input | 1 | Counter reached zero in this tick |
| evt_prd | input | 1 | Counter reached the period in this tick |
| evt_cmpa_up | input | 1 | Compare A match while counting up |
| evt_cmpb_up | input | 1 | Compare B match while counting up |
| pwm_a | output | 1 | Output A level |
| pwm_b | output | 1 | Output B level |

## Verification
An event result is due one edge after the tick that carries it. A register write takes effect on the edge that samples `wr_en`. A newly written force value is due on the first tick whose events match the reload mode; in immediate mode that is the first tick after the write. The bench drives all inputs on the falling edge and holds each tick for exactly one cycle. It reads the outputs on the next falling edge, after the one rising edge that is due. Force cases check both the non-loading tick (old behaviour still holds) and the loading tick (new level appears), so an early or late load shows up.

// File: rtl/aq_pkg.sv
// Shared types and constants for the PWM action qualifier.
// Assumes the time-base counter supplies one-tick event pulses.
package aq_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } aq_act_e;

    typedef enum logic [1:0] {
        RLD_ZERO   = 2'b00,
        RLD_PRD    = 2'b01,
        RLD_EITHER = 2'b10,
        RLD_NOW    = 2'b11
    } aq_rld_e;

    // Bit positions of each event action inside a control word
    localparam int FLD_ZERO_LSB = 0;
    localparam int FLD_PRD_LSB  = 2;
    localparam int FLD_CMPA_LSB = 4;
    localparam int FLD_CMPB_LSB = 8;

    // Register addresses on the write port
    localparam logic [1:0] ADDR_CTL_A = 2'd0;
    localparam logic [1:0] ADDR_CTL_B = 2'd1;
    localparam logic [1:0] ADDR_FORCE = 2'd2;
    localparam logic [1:0] ADDR_RLD   = 2'd3;

    // Next output level for an action applied to the current level
    function automatic logic apply_act(input aq_act_e act, input logic cur);
        case (act)
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/aq_event_sel.sv
// Picks the winning action for one output from the events of a tick.
// Priority: compare B, then compare A, then period, then zero.
// An event counts only if present and its action code is non-zero.
module aq_event_sel
    import aq_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] ctl_word,
    input  logic          evt_zero,
    input  logic          evt_prd,
    input  logic          evt_cmpa_up,
    input  logic          evt_cmpb_up,
    output aq_act_e       act
);

    aq_act_e f_zero, f_prd, f_cmpa, f_cmpb;

    // Slice the four action fields out of the control word
    always_comb begin
        f_zero = aq_act_e'(ctl_word[FLD_ZERO_LSB +: 2]);
        f_prd  = aq_act_e'(ctl_word[FLD_PRD_LSB  +: 2]);
        f_cmpa = aq_act_e'(ctl_word[FLD_CMPA_LSB +: 2]);
        f_cmpb = aq_act_e'(ctl_word[FLD_CMPB_LSB +: 2]);
    end

    // Later assignment wins, so the order gives the priority
    always_comb begin
        act = ACT_NONE;
        if (evt_zero    && f_zero != ACT_NONE) act = f_zero;
        if (evt_prd     && f_prd  != ACT_NONE) act = f_prd;
        if (evt_cmpa_up && f_cmpa != ACT_NONE) act = f_cmpa;
        if (evt_cmpb_up && f_cmpb != ACT_NONE) act = f_cmpb;
    end

endmodule

// File: rtl/aq_force_ctl.sv
// Shadow-to-active reload for one channel's continuous force code.
// The active code loads on a tick matching the reload mode; on that
// tick the newly loaded code already decides the output.
module aq_force_ctl
    import aq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       evt_zero,
    input  logic       evt_prd,
    input  aq_rld_e    rld_mode,
    input  logic [1:0] shadow,
    output logic       frc_en,
    output logic       frc_lvl
);

    logic [1:0] active_q;
    logic [1:0] eff;
    logic       load;

    // Decide whether this tick moves the shadow into the active copy
    always_comb begin
        case (rld_mode)
            RLD_ZERO:   load = tick && evt_zero;
            RLD_PRD:    load = tick && evt_prd;
            RLD_EITHER: load = tick && (evt_zero || evt_prd);
            default:    load = tick;
        endcase
    end

    // Effective code for this tick and its decoded meaning
    always_comb begin
        eff     = load ? shadow : active_q;
        frc_en  = (eff == 2'b01) || (eff == 2'b10);
        frc_lvl = (eff == 2'b10);
    end

    // Hold the active force code
    always_ff @(posedge clk) begin
        if (!rst_n)    active_q <= 2'b00;
        else if (load) active_q <= shadow;
    end

endmodule

// File: rtl/aq_out_stage.sv
// Output level register for one channel. Updates only on tick;
// an active force takes precedence over the event action.
module aq_out_stage
    import aq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  aq_act_e act,
    input  logic    frc_en,
    input  logic    frc_lvl,
    output logic    out_q
);

    // Apply force or event action once per tick
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= 1'b0;
        else if (tick) begin
            if (frc_en)  out_q <= frc_lvl;
            else         out_q <= apply_act(act, out_q);
        end
    end

endmodule

// File: rtl/pwm_action_qual.sv
// Two-channel PWM action qualifier. Holds the configuration registers
// and instantiates per-channel event selection, force reload and
// output stages. Assumes event inputs are valid only with tick.
module pwm_action_qual
    import aq_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          tick,
    input  logic          evt_zero,
    input  logic          evt_prd,
    input  logic          evt_cmpa_up,
    input  logic          evt_cmpb_up,
    output logic          pwm_a,
    output logic          pwm_b
);

    localparam int NUM_CH = 2;
    localparam int FW     = 2 * NUM_CH;

    logic [NUM_CH-1:0][DW-1:0] ctl_q;
    logic [FW-1:0]             frc_shadow_q;
    aq_rld_e                   rld_q;
    logic [NUM_CH-1:0][1:0]    act_sel;
    logic [NUM_CH-1:0]         frc_en;
    logic [NUM_CH-1:0]         frc_lvl;
    logic [NUM_CH-1:0]         out_q;

    // Configuration register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q        <= '0;
            frc_shadow_q <= '0;
            rld_q        <= RLD_ZERO;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTL_A: ctl_q[0]     <= wr_data;
                ADDR_CTL_B: ctl_q[1]     <= wr_data;
                ADDR_FORCE: frc_shadow_q <= wr_data[FW-1:0];
                default:    rld_q        <= aq_rld_e'(wr_data[1:0]);
            endcase
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        aq_act_e act_w;

        aq_event_sel #(.DW(DW)) u_sel (
            .ctl_word    (ctl_q[ch]),
            .evt_zero    (evt_zero),
            .evt_prd     (evt_prd),
            .evt_cmpa_up (evt_cmpa_up),
            .evt_cmpb_up (evt_cmpb_up),
            .act         (act_w)
        );

        assign act_sel[ch] = act_w;

        aq_force_ctl u_frc (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .evt_zero (evt_zero),
            .evt_prd  (evt_prd),
            .rld_mode (rld_q),
            .shadow   (frc_shadow_q[2*ch +: 2]),
            .frc_en   (frc_en[ch]),
            .frc_lvl  (frc_lvl[ch])
        );

        aq_out_stage u_out (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .act     (act_w),
            .frc_en  (frc_en[ch]),
            .frc_lvl (frc_lvl[ch]),
            .out_q   (out_q[ch])
        );
    end

    assign pwm_a = out_q[0];
    assign pwm_b = out_q[1];

endmodule

// File: rtl/aq_checker.sv
// Temporal checks on the action qualifier, bound to its top module.
module aq_checker (
    input logic            clk,
    input logic            rst_n,
    input logic            tick,
    input logic            pwm_a,
    input logic            pwm_b,
    input logic [1:0][1:0] act_sel,
    input logic [1:0]      frc_en,
    input logic [1:0]      frc_lvl
);

    // R3
    out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(pwm_a) && $stable(pwm_b)));

    // R5
    force_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && frc_en[0]) |=> (pwm_a == $past(frc_lvl[0])));

    // R5
    force_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && frc_en[1]) |=> (pwm_b == $past(frc_lvl[1])));

    // R1
    act_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !frc_en[0] && act_sel[0] == 2'b10) |=> pwm_a);

    // R1
    act_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !frc_en[1] && act_sel[1] == 2'b01) |=> !pwm_b);

    // R1
    act_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !frc_en[0] && act_sel[0] == 2'b11) |=> (pwm_a != $past(pwm_a)));

    // R1
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !frc_en[1] && act_sel[1] == 2'b00) |=> $stable(pwm_b));

endmodule

bind pwm_action_qual aq_checker u_aq_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .pwm_a   (pwm_a),
    .pwm_b   (pwm_b),
    .act_sel (act_sel),
    .frc_en  (frc_en),
    .frc_lvl (frc_lvl)
);

// File: tb/pwm_action_qual_bench.sv
module pwm_action_qual_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        tick = 1'b0;
    logic        evt_zero = 1'b0, evt_prd = 1'b0, evt_cmpa_up = 1'b0, evt_cmpb_up = 1'b0;
    logic        pwm_a, pwm_b;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    pwm_action_qual u_pwm_action_qual (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick(tick), .evt_zero(evt_zero),
        .evt_prd(evt_prd), .evt_cmpa_up(evt_cmpa_up),
        .evt_cmpb_up(evt_cmpb_up), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One tick with the given events; returns at the falling edge after it
    task automatic step(input logic z, input logic p, input logic ca, input logic cb);
        @(negedge clk);
        tick = 1'b1; evt_zero = z; evt_prd = p; evt_cmpa_up = ca; evt_cmpb_up = cb;
        @(negedge clk);
        tick = 1'b0; evt_zero = 1'b0; evt_prd = 1'b0; evt_cmpa_up = 1'b0; evt_cmpb_up = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 pwm_a after reset", pwm_a, 1'b0);
        check("R10 pwm_b after reset", pwm_b, 1'b0);
        step(1, 1, 1, 1);
        check("R10 cleared fields keep pwm_a low", pwm_a, 1'b0);
        check("R10 cleared fields keep pwm_b low", pwm_b, 1'b0);
    endtask

    task automatic t_normal_a();
        wr(2'd0, 16'h001A);               // zero high, period high, cmpA low
        step(1, 0, 0, 0); check("R2 zero field sets A high", pwm_a, 1'b1);
        step(0, 0, 1, 0); check("R1 cmpA low clears A", pwm_a, 1'b0);
        step(0, 1, 0, 0); check("R2 period field sets A high", pwm_a, 1'b1);
        step(0, 0, 0, 1); check("R2 empty cmpB field holds A", pwm_a, 1'b1);
        check("R2 B untouched by A word", pwm_b, 1'b0);
    endtask

    task automatic t_inverted_b();
        wr(2'd1, 16'h0205);               // zero low, period low, cmpB high
        step(0, 0, 0, 1); check("R2 cmpB field sets B high", pwm_b, 1'b1);
        step(1, 0, 0, 0); check("R1 zero low clears B", pwm_b, 1'b0);
        step(0, 0, 0, 1); check("R1 cmpB high again", pwm_b, 1'b1);
        step(0, 1, 0, 0); check("R1 period low clears B", pwm_b, 1'b0);
    endtask

    task automatic t_toggle();
        wr(2'd0, 16'h0003);               // zero toggles A (A is 1 now)
        step(1, 0, 0, 0); check("R1 toggle to low", pwm_a, 1'b0);
        step(1, 0, 0, 0); check("R1 toggle to high", pwm_a, 1'b1);
        @(negedge clk); evt_zero = 1'b1;
        @(negedge clk); evt_zero = 1'b0;
        check("R3 event without tick ignored", pwm_a, 1'b1);
    endtask

    task automatic t_priority();
        wr(2'd0, 16'h0126);               // zero high, period low, cmpA high, cmpB low
        step(1, 1, 0, 0); check("R4 period beats zero", pwm_a, 1'b0);
        step(1, 0, 0, 0); check("R4 zero alone", pwm_a, 1'b1);
        step(0, 1, 0, 0); check("R4 period alone", pwm_a, 1'b0);
        step(1, 1, 1, 0); check("R4 cmpA beats period", pwm_a, 1'b1);
        step(0, 0, 1, 1); check("R4 cmpB beats cmpA", pwm_a, 1'b0);
        wr(2'd0, 16'h0002);               // zero high only, cmpA code 00
        step(1, 0, 1, 0); check("R4 code 00 does not mask zero", pwm_a, 1'b1);
    endtask

    task automatic t_force_zero();
        wr(2'd0, 16'h0011);               // zero low, cmpA low
        step(0, 0, 1, 0); check("R4 setup A low", pwm_a, 1'b0);
        wr(2'd2, 16'h0002);               // force A high, mode 00
        step(0, 1, 0, 0); check("R6 period does not load in zero mode", pwm_a, 1'b0);
        step(1, 0, 0, 0); check("R6 zero loads force high", pwm_a, 1'b1);
        step(0, 0, 1, 0); check("R5 force overrides cmpA low", pwm_a, 1'b1);
        wr(2'd2, 16'h0000);
        step(0, 0, 1, 0); check("R6 release waits for zero", pwm_a, 1'b1);
        step(1, 0, 0, 0); check("R6 release at zero, zero low acts", pwm_a, 1'b0);
    endtask

    task automatic t_force_period();
        wr(2'd3, 16'h0001);
        wr(2'd2, 16'h0002);
        step(1, 0, 0, 0); check("R7 zero does not load in period mode", pwm_a, 1'b0);
        step(0, 1, 0, 0); check("R7 period loads force high", pwm_a, 1'b1);
        wr(2'd2, 16'h0000);
        step(0, 1, 0, 0); check("R7 release loaded, level held", pwm_a, 1'b1);
        step(0, 0, 1, 0); check("R7 events act after release", pwm_a, 1'b0);
    endtask

    task automatic t_force_either();
        wr(2'd3, 16'h0002);
        step(0, 0, 0, 1); check("R8 setup B high", pwm_b, 1'b1);
        wr(2'd2, 16'h0004);               // force B low
        step(0, 0, 0, 1); check("R8 cmpB tick does not load", pwm_b, 1'b1);
        step(0, 1, 0, 0); check("R8 period loads force low", pwm_b, 1'b0);
        step(0, 0, 0, 1); check("R5 force low overrides cmpB high", pwm_b, 1'b0);
        wr(2'd2, 16'h0008);               // force B high
        step(1, 0, 0, 0); check("R8 zero loads force high", pwm_b, 1'b1);
        check("R5 A unforced by B field", pwm_a, 1'b0);
    endtask

    task automatic t_force_now();
        wr(2'd3, 16'h0003);
        wr(2'd2, 16'h0004);               // force B low, immediate
        step(0, 0, 0, 0); check("R9 immediate force on next tick", pwm_b, 1'b0);
        wr(2'd2, 16'h000C);               // code 11: unforced
        step(0, 0, 0, 0); check("R5 code 11 releases, no action holds", pwm_b, 1'b0);
        step(0, 0, 0, 1); check("R5 code 11 lets cmpB act", pwm_b, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal_a();
        t_inverted_b();
        t_toggle();
        t_priority();
        t_force_zero();
        t_force_period();
        t_force_either();
        t_force_now();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule